// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates a set of interrupt lines for a single CPU and supports nested handling. Each line has a 3-bit priority, an enable bit and a pending bit. The pending bit is set while the line's level source is high, or by a software write, and it can be cleared by software. Among the lines that are pending, enabled and not masked, the block picks one. It raises a request to the CPU with an exception number and a vector fetch address. The address is taken from a table base that software can relocate.

A grouping setting divides each priority into a preemption field and a subpriority field. A request is raised only when the winner's preemption level is strictly more urgent than the most urgent handler that is already running. The running handlers are held as a stack of active preemption levels. An interrupt at the same level waits and is taken back-to-back once the current handler returns. A separate non-maskable input bypasses the enables, the priorities and the global gate.

Software writes a small register port. The CPU side is two single-cycle strobes: accept, which takes the current request, and return, which ends the innermost handler.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every enable and pending bit is 0, all priorities are 0, the global gate is open, the threshold is 0, the grouping is 0, the table base is 0, and `req_o` is 0.
- R2: A line is requested only if its pending bit and its enable bit are both set. A pending bit is set by a write to address 2 (a 1 in bit i sets line i), or by a high `src_i[i]` seen at a clock edge while line i is not active. Address 0 sets enable bits and address 1 clears them, using the same bit mapping.
- R3: The winner is the line with the numerically lowest full 3-bit priority. Lines with equal priority are decided by the lowest line number. Priorities are written at address 4, with the line in data[15:8] and the priority in data[2:0].
- R4: Address 5 holds the threshold in data[6:4]. A nonzero threshold T blocks every line whose priority is T or higher. A threshold of 0 blocks nothing.
- R5: Address 5 data[0] is the global gate. While the gate is 0, no line is requested and the enable bits are left as they were. A rising edge on `nmi_i` still produces a request with exception number 2.
- R6: An accept (`ack_i` while `req_o` is high) clears the winner's pending bit. A write to address 3 clears the pending bits given by the 1s in the data.
- R7: Address 5 data[9:8] holds the grouping M (0 to 3). The preemption level is priority >> M. A line is requested while handlers are active only if its level is strictly lower than the level of the innermost active handler.
- R8: A line at the same level as the innermost active handler is held back. After `ret_i` it is requested, and waiting lines at that level are served in order of full priority.
- R9: `vec_addr_o` = base + 4 × `exc_num_o`. Line i has exception number 16 + i and the non-maskable input has 2. The base is written at address 6, and its bits [7:0] are always forced to 0.
- R10: A source that is still high after its handler returns sets its pending bit again one cycle after the return. It does not set it while its handler is active.
- R11: An accepted non-maskable request preempts any running line handler. While it is active, `req_o` stays 0 until `ret_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | N_LINES | Level-sensitive interrupt sources |
| nmi_i | input | 1 | Non-maskable source, rising-edge sensitive |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| ack_i | input | 1 | CPU accepts the current request |
| ret_i | input | 1 | CPU returns from the innermost handler |
| req_o | output | 1 | A request is presented |
| exc_num_o | output | 8 | Exception number of the request (0 when idle) |
| vec_addr_o | output | ADDR_W | Vector fetch address |
| pend_o | output | N_LINES | Pending bits |

## Verification
The hardest state to reach from the ports is a nested one: a handler is active at a chosen preemption level, and a second pending line sits at a level that may or may not beat it. The bench builds this case in every combination of grouping and the two priorities. It programs both priorities, accepts the first line, pends the second through a register write, and compares `req_o` with the shifted levels it computes itself. Tail-chain order and the re-pending of level sources are then checked by driving sequences of accepts and returns.

// File: rtl/pic_pkg.sv
package pic_pkg;
   typedef enum logic [2:0] {
      RA_EN_SET = 3'd0,
      RA_EN_CLR = 3'd1,
      RA_PD_SET = 3'd2,
      RA_PD_CLR = 3'd3,
      RA_PRIO   = 3'd4,
      RA_CTRL   = 3'd5,
      RA_BASE   = 3'd6
   } reg_addr_e;

   localparam int unsigned EXC_W         = 8;
   localparam int unsigned NMI_EXC       = 2;
   localparam int unsigned LINE_EXC_BASE = 16;
   localparam int unsigned BASE_ALIGN    = 8;
   localparam int unsigned PRIO_LINE_LSB = 8;
   localparam int unsigned CTRL_THR_LSB  = 4;
   localparam int unsigned CTRL_GRP_LSB  = 8;
endpackage

// File: rtl/pic_regfile.sv
module pic_regfile
   import pic_pkg::*;
#(
   parameter int unsigned N_LINES = 8,
   parameter int unsigned PRIO_W  = 3,
   parameter int unsigned ADDR_W  = 32,
   localparam int unsigned LINE_W = $clog2(N_LINES),
   localparam int unsigned GRP_W  = $clog2(PRIO_W + 1)
) (
   input  logic                            clk_i,
   input  logic                            rst_ni,
   input  logic                            wr_en_i,
   input  logic [2:0]                      wr_addr_i,
   input  logic [31:0]                     wr_data_i,
   input  logic [N_LINES-1:0]              src_i,
   input  logic [N_LINES-1:0]              busy_i,
   input  logic [N_LINES-1:0]              ack_clr_i,
   output logic [N_LINES-1:0]              en_q,
   output logic [N_LINES-1:0]              pend_q,
   output logic [N_LINES-1:0][PRIO_W-1:0]  prio_q,
   output logic                            gate_q,
   output logic [PRIO_W-1:0]               thr_q,
   output logic [GRP_W-1:0]                grp_q,
   output logic [ADDR_W-1:0]               base_q
);
   logic [N_LINES-1:0] sw_set, sw_clr, pend_next;
   logic [LINE_W-1:0]  prio_idx;

   assign prio_idx = wr_data_i[PRIO_LINE_LSB +: LINE_W];

   always_comb begin
      sw_set = (wr_en_i && wr_addr_i == RA_PD_SET) ? wr_data_i[N_LINES-1:0] : '0;
      sw_clr = (wr_en_i && wr_addr_i == RA_PD_CLR) ? wr_data_i[N_LINES-1:0] : '0;
      // accept clear is applied last so it always wins
      pend_next = ((pend_q | (src_i & ~busy_i) | sw_set) & ~sw_clr) & ~ack_clr_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         en_q   <= '0;
         pend_q <= '0;
         prio_q <= '0;
         gate_q <= 1'b1;
         thr_q  <= '0;
         grp_q  <= '0;
         base_q <= '0;
      end else begin
         pend_q <= pend_next;
         if (wr_en_i) begin
            case (wr_addr_i)
               RA_EN_SET: en_q <= en_q | wr_data_i[N_LINES-1:0];
               RA_EN_CLR: en_q <= en_q & ~wr_data_i[N_LINES-1:0];
               RA_PRIO: begin
                  if (int'(prio_idx) < N_LINES)
                     prio_q[prio_idx] <= wr_data_i[PRIO_W-1:0];
               end
               RA_CTRL: begin
                  gate_q <= wr_data_i[0];
                  thr_q  <= wr_data_i[CTRL_THR_LSB +: PRIO_W];
                  grp_q  <= wr_data_i[CTRL_GRP_LSB +: GRP_W];
               end
               RA_BASE: base_q <= {wr_data_i[ADDR_W-1:BASE_ALIGN], {BASE_ALIGN{1'b0}}};
               default: ;
            endcase
         end
      end
   end

   p_base_aligned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && wr_addr_i == RA_BASE |=> base_q[BASE_ALIGN-1:0] == '0);
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
   parameter int unsigned N_LINES = 8,
   parameter int unsigned PRIO_W  = 3,
   localparam int unsigned LINE_W = $clog2(N_LINES)
) (
   input  logic [N_LINES-1:0]             elig_i,
   input  logic [N_LINES-1:0][PRIO_W-1:0] prio_i,
   output logic                           found_o,
   output logic [LINE_W-1:0]              line_o,
   output logic [PRIO_W-1:0]              prio_o
);
   // ascending scan with strict compare: equal priority keeps the lower line
   always_comb begin
      found_o = 1'b0;
      line_o  = '0;
      prio_o  = '1;
      for (int i = 0; i < int'(N_LINES); i++) begin
         if (elig_i[i] && (!found_o || prio_i[i] < prio_o)) begin
            found_o = 1'b1;
            line_o  = LINE_W'(i);
            prio_o  = prio_i[i];
         end
      end
   end
endmodule

// File: rtl/pic_nest_stack.sv
module pic_nest_stack #(
   parameter int unsigned N_LINES = 8,
   parameter int unsigned PRIO_W  = 3,
   localparam int unsigned LINE_W = $clog2(N_LINES),
   localparam int unsigned LEVELS = 2 ** PRIO_W
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                push_i,
   input  logic [PRIO_W-1:0]   push_lvl_i,
   input  logic [LINE_W-1:0]   push_line_i,
   input  logic                pop_i,
   output logic                top_valid_o,
   output logic [PRIO_W-1:0]   top_lvl_o,
   output logic [N_LINES-1:0]  busy_o
);
   // one slot per preemption level: nesting is strictly ordered by level
   logic [LEVELS-1:0]             lvl_act_q;
   logic [LEVELS-1:0][LINE_W-1:0] line_at_q;

   always_comb begin
      top_valid_o = 1'b0;
      top_lvl_o   = '0;
      for (int l = LEVELS - 1; l >= 0; l--) begin
         if (lvl_act_q[l]) begin
            top_valid_o = 1'b1;
            top_lvl_o   = PRIO_W'(l);
         end
      end
   end

   always_comb begin
      busy_o = '0;
      for (int l = 0; l < int'(LEVELS); l++)
         if (lvl_act_q[l]) busy_o[line_at_q[l]] = 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         lvl_act_q <= '0;
         line_at_q <= '0;
      end else if (push_i) begin
         lvl_act_q[push_lvl_i] <= 1'b1;
         line_at_q[push_lvl_i] <= push_line_i;
      end else if (pop_i) begin
         lvl_act_q[top_lvl_o] <= 1'b0;
      end
   end

   p_push_urgent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_i && top_valid_o |-> push_lvl_i < top_lvl_o);
   p_pop_nonempty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_i |-> top_valid_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import pic_pkg::*;
#(
   parameter int unsigned N_LINES = 8,
   parameter int unsigned PRIO_W  = 3,
   parameter int unsigned ADDR_W  = 32,
   localparam int unsigned LINE_W = $clog2(N_LINES),
   localparam int unsigned GRP_W  = $clog2(PRIO_W + 1)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [N_LINES-1:0]  src_i,
   input  logic                nmi_i,
   input  logic                wr_en_i,
   input  logic [2:0]          wr_addr_i,
   input  logic [31:0]         wr_data_i,
   input  logic                ack_i,
   input  logic                ret_i,
   output logic                req_o,
   output logic [EXC_W-1:0]    exc_num_o,
   output logic [ADDR_W-1:0]   vec_addr_o,
   output logic [N_LINES-1:0]  pend_o
);
   if (N_LINES < 2 || N_LINES > 32) begin : g_bad_lines
      $error("N_LINES must be 2..32");
   end
   if (PRIO_W < 1 || PRIO_W > 4) begin : g_bad_prio
      $error("PRIO_W must be 1..4");
   end
   if (ADDR_W <= BASE_ALIGN || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must be 9..32");
   end

   logic [N_LINES-1:0]             en_q, pend_q, busy, ack_clr, thr_ok, elig;
   logic [N_LINES-1:0][PRIO_W-1:0] prio_q;
   logic                           gate_q, found, top_valid, preempt_ok;
   logic [PRIO_W-1:0]              thr_q, win_prio, win_lvl, top_lvl;
   logic [GRP_W-1:0]               grp_q;
   logic [ADDR_W-1:0]              base_q;
   logic [LINE_W-1:0]              win_line;
   logic                           nmi_q, nmi_pend_q, nmi_act_q, nmi_win;
   logic                           accept, push, pop;

   pic_regfile #(.N_LINES(N_LINES), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) regs_i (
      .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .src_i,
      .busy_i(busy), .ack_clr_i(ack_clr),
      .en_q, .pend_q, .prio_q, .gate_q, .thr_q, .grp_q, .base_q);

   for (genvar i = 0; i < int'(N_LINES); i++) begin : g_elig
      assign thr_ok[i] = (thr_q == '0) || (prio_q[i] < thr_q);
      assign elig[i]   = pend_q[i] && en_q[i] && gate_q && thr_ok[i];
   end

   pic_arbiter #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) arb_i (
      .elig_i(elig), .prio_i(prio_q),
      .found_o(found), .line_o(win_line), .prio_o(win_prio));

   assign win_lvl    = win_prio >> grp_q;
   assign preempt_ok = !top_valid || (win_lvl < top_lvl);
   assign nmi_win    = nmi_pend_q && !nmi_act_q;
   assign req_o      = nmi_win || (!nmi_act_q && found && preempt_ok);
   assign accept     = ack_i && req_o && !ret_i;
   assign push       = accept && !nmi_win;
   assign pop        = ret_i && !nmi_act_q && top_valid;

   always_comb begin
      ack_clr = '0;
      if (push) ack_clr[win_line] = 1'b1;
   end

   always_comb begin
      if (nmi_win)    exc_num_o = EXC_W'(NMI_EXC);
      else if (req_o) exc_num_o = EXC_W'(LINE_EXC_BASE) + EXC_W'(win_line);
      else            exc_num_o = '0;
   end
   assign vec_addr_o = base_q + ADDR_W'({exc_num_o, 2'b00});
   assign pend_o     = pend_q;

   pic_nest_stack #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) stack_i (
      .clk_i, .rst_ni, .push_i(push), .push_lvl_i(win_lvl), .push_line_i(win_line),
      .pop_i(pop), .top_valid_o(top_valid), .top_lvl_o(top_lvl), .busy_o(busy));

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         nmi_q      <= 1'b0;
         nmi_pend_q <= 1'b0;
         nmi_act_q  <= 1'b0;
      end else begin
         nmi_q <= nmi_i;
         if (nmi_i && !nmi_q)      nmi_pend_q <= 1'b1;
         else if (accept && nmi_win) nmi_pend_q <= 1'b0;
         if (accept && nmi_win)    nmi_act_q <= 1'b1;
         else if (ret_i)           nmi_act_q <= 1'b0;
      end
   end

   p_req_enabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o && !nmi_win |-> en_q[win_line] && pend_q[win_line]);
   p_threshold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o && !nmi_win && thr_q != '0 |-> prio_q[win_line] < thr_q);
   p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gate_q && req_o |-> exc_num_o == EXC_W'(NMI_EXC));
   p_ack_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push |=> !pend_q[$past(win_line)]);
   p_nmi_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nmi_act_q |-> !req_o);
   p_busy_no_repend_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push |=> busy[$past(win_line)]);
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [N-1:0] src;
   logic        nmi, wr_en, ack, ret;
   logic [2:0]  wr_addr;
   logic [31:0] wr_data;
   logic        req;
   logic [7:0]  exc;
   logic [31:0] vec;
   logic [N-1:0] pend;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   prio_irq_ctrl #(.N_LINES(N), .PRIO_W(3), .ADDR_W(32)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .src_i(src), .nmi_i(nmi),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .ack_i(ack), .ret_i(ret), .req_o(req), .exc_num_o(exc),
      .vec_addr_o(vec), .pend_o(pend));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_ack();
      ack = 1'b1; @(negedge clk); ack = 1'b0;
   endtask

   task automatic do_ret();
      ret = 1'b1; @(negedge clk); ret = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; src = '0; nmi = 1'b0; wr_en = 1'b0; ack = 1'b0; ret = 1'b0;
      wr_addr = '0; wr_data = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic logic [31:0] ctrl(input int gate, input int thr, input int grp);
      return 32'(gate) | (32'(thr) << 4) | (32'(grp) << 8);
   endfunction

   function automatic logic [31:0] prio_wd(input int line, input int p);
      return (32'(line) << 8) | 32'(p);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 req", 32'(req), 0);
      chk("R1 pend", 32'(pend), 0);
      chk("R1 exc", 32'(exc), 0);

      // R2 pending without enable is not requested
      wr(3'd2, 32'h08);
      chk("R2 pend set", 32'(pend), 32'h08);
      chk("R2 no enable", 32'(req), 0);
      wr(3'd0, 32'h08);
      chk("R2 enabled req", 32'(req), 1);
      chk("R2 exc", 32'(exc), 19);
      wr(3'd1, 32'h08);
      chk("R2 enable cleared", 32'(req), 0);
      src[5] = 1'b1; cyc(); src[5] = 1'b0;
      chk("R2 source pend", 32'(pend), 32'h28);

      // R6 software clear
      wr(3'd3, 32'h28);
      chk("R6 sw clear", 32'(pend), 0);

      // R3 distinct-priority pairs
      for (int a = 0; a < N; a++) begin
         for (int b = 0; b < N; b++) begin
            if (a != b) begin
               int pa, pb, w;
               pa = (a * 3) % 8; pb = (b * 5 + 1) % 8;
               do_reset();
               wr(3'd4, prio_wd(a, pa));
               wr(3'd4, prio_wd(b, pb));
               wr(3'd0, (32'd1 << a) | (32'd1 << b));
               wr(3'd2, (32'd1 << a) | (32'd1 << b));
               if (pa < pb) w = a;
               else if (pb < pa) w = b;
               else w = (a < b) ? a : b;
               chk("R3 pair winner", 32'(exc), 32'(16 + w));
            end
         end
      end

      // R3 equal priority: lowest line wins, all masks
      do_reset();
      for (int l = 0; l < N; l++) wr(3'd4, prio_wd(l, 4));
      wr(3'd0, 32'hFF);
      for (int m = 1; m < 256; m++) begin
         int low;
         low = 0;
         for (int k = 7; k >= 0; k--) if (m[k]) low = k;
         wr(3'd3, 32'hFF);
         wr(3'd2, 32'(m));
         chk("R3 tie lowest line", 32'(exc), 32'(16 + low));
      end

      // R4 threshold sweep
      do_reset();
      wr(3'd0, 32'h04);
      wr(3'd2, 32'h04);
      for (int t = 0; t < 8; t++) begin
         for (int p = 0; p < 8; p++) begin
            wr(3'd4, prio_wd(2, p));
            wr(3'd5, ctrl(1, t, 0));
            chk("R4 threshold", 32'(req), (t == 0 || p < t) ? 1 : 0);
         end
      end

      // R5 global gate
      do_reset();
      wr(3'd0, 32'h02);
      wr(3'd2, 32'h02);
      wr(3'd5, ctrl(0, 0, 0));
      chk("R5 gate closed", 32'(req), 0);
      chk("R5 pend kept", 32'(pend), 32'h02);
      nmi = 1'b1; cyc(); cyc();
      chk("R5 nmi req", 32'(req), 1);
      chk("R5 nmi exc", 32'(exc), 2);
      chk("R9 nmi vec", vec, 32'h8);
      nmi = 1'b0;
      do_ack();
      do_ret();
      chk("R5 gate still closed", 32'(req), 0);
      wr(3'd5, ctrl(1, 0, 0));
      chk("R5 enable kept", 32'(exc), 17);

      // R9 vector address sweep
      do_reset();
      wr(3'd6, 32'h123456FF);
      wr(3'd0, 32'hFF);
      for (int l = 0; l < N; l++) begin
         wr(3'd3, 32'hFF);
         wr(3'd2, 32'd1 << l);
         chk("R9 vector", vec, 32'h12345600 + 32'(4 * (16 + l)));
      end

      // R6 accept clears pending
      do_reset();
      wr(3'd0, 32'h01);
      wr(3'd2, 32'h01);
      do_ack();
      chk("R6 accept clears", 32'(pend), 0);
      chk("R6 req after accept", 32'(req), 0);

      // R7 preemption sweep over grouping and both priorities
      for (int g = 0; g < 4; g++) begin
         for (int p1 = 0; p1 < 8; p1++) begin
            for (int p2 = 0; p2 < 8; p2++) begin
               do_reset();
               wr(3'd5, ctrl(1, 0, g));
               wr(3'd4, prio_wd(0, p1));
               wr(3'd4, prio_wd(1, p2));
               wr(3'd0, 32'h03);
               wr(3'd2, 32'h01);
               do_ack();
               wr(3'd2, 32'h02);
               chk("R7 preempt", 32'(req), ((p2 >> g) < (p1 >> g)) ? 1 : 0);
            end
         end
      end

      // R8 tail chaining inside one preemption level
      do_reset();
      wr(3'd5, ctrl(1, 0, 2));
      wr(3'd4, prio_wd(4, 2));
      wr(3'd4, prio_wd(5, 3));
      wr(3'd4, prio_wd(6, 1));
      wr(3'd0, 32'h70);
      wr(3'd2, 32'h10);
      do_ack();
      wr(3'd2, 32'h60);
      chk("R8 held same level", 32'(req), 0);
      do_ret();
      chk("R8 first chained", 32'(exc), 22);
      do_ack();
      chk("R8 second held", 32'(req), 0);
      do_ret();
      chk("R8 second chained", 32'(exc), 21);

      // R10 level source re-pends after return
      do_reset();
      wr(3'd0, 32'h08);
      src[3] = 1'b1; cyc();
      chk("R10 source req", 32'(exc), 19);
      do_ack();
      cyc(); cyc();
      chk("R10 no repend while active", 32'(pend), 0);
      do_ret();
      cyc();
      chk("R10 repend after return", 32'(pend), 32'h08);
      src[3] = 1'b0;
      do_ack();
      do_ret();
      cyc();
      chk("R10 low source stays clear", 32'(pend), 0);

      // R11 NMI over a running line handler
      do_reset();
      wr(3'd4, prio_wd(0, 7));
      wr(3'd0, 32'h03);
      wr(3'd2, 32'h01);
      do_ack();
      nmi = 1'b1; cyc(); cyc(); nmi = 1'b0;
      chk("R11 nmi preempts", 32'(exc), 2);
      do_ack();
      wr(3'd2, 32'h02);
      chk("R11 nothing during nmi", 32'(req), 0);
      do_ret();
      chk("R11 line after nmi", 32'(exc), 17);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule